// File: doc/BRIEF.md
# Nibble-Serial Status Frame Transmitter

The block sends a 128-bit status frame over a narrow parallel link, one four-bit nibble at a time, frame after frame with no gap. The link has three parts: a clock line the block generates, a start-of-frame line, and a four-bit data bus. A receiver latches the bus and the start-of-frame line on each rising edge of the link clock.

The frame holds a column-ordered key matrix image (nine columns of eight rows), two joysticks with four directions and a fire button each, the caps lock, restore and reset switch states, and an expansion area that is sent as zeros. The block takes a snapshot of all inputs only when a new frame begins. Data and start-of-frame change on the falling edge of the link clock, so they are stable for a full half period before the receiver's rising edge.

Top module: `nib_frame_tx`

## Requirements
- R1: While `rst_ni` is low, `link_clk_o` is 1, `link_sof_o` is 0 and `link_data_o` is 0.
- R2: After reset the link clock spends exactly `HALF_DIV` system cycles high and `HALF_DIV` system cycles low in every period.
- R3: `link_data_o` and `link_sof_o` change only in the system cycle where `link_clk_o` falls. They are therefore stable for at least `HALF_DIV` cycles before each rising edge.
- R4: A frame is 32 nibbles, sent one per link clock period. `link_sof_o` is 1 during nibble 0 of every frame and 0 during the other 31.
- R5: Key input bit `8*k + r` is key column k, row r. Nibble `2k` carries rows 0 to 3 of column k in bits 0 to 3. Nibble `2k+1` carries rows 4 to 7 in bits 0 to 3. This covers nibbles 0 to 17.
- R6: Joystick inputs use bit 0 = up, bit 1 = down, bit 2 = left, bit 3 = right, bit 4 = fire. Nibble 18 carries joystick 1 bits 0 to 3. Nibble 20 carries joystick 2 bits 0 to 3.
- R7: Nibble 19 is {restore, caps lock, 0, joystick 1 fire} from bit 3 down to bit 0. Nibble 21 is {reset switch, 0, 0, joystick 2 fire} from bit 3 down to bit 0.
- R8: Nibbles 22 to 31 are all zero.
- R9: Every nibble of a frame comes from the inputs sampled at the link clock falling edge that starts that frame. Input changes during a frame do not reach the link until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| keys_i | input | NUM_COLS*8 | Key matrix image, column-major, 1 = pressed |
| joy1_i | input | 5 | Joystick 1 {fire, right, left, down, up} |
| joy2_i | input | 5 | Joystick 2 {fire, right, left, down, up} |
| caps_i | input | 1 | Caps lock state |
| restore_i | input | 1 | Restore key state |
| reset_sw_i | input | 1 | Reset switch state |
| link_clk_o | output | 1 | Link clock; receiver samples on its rising edge |
| link_sof_o | output | 1 | High during the first nibble of each frame |
| link_data_o | output | 4 | Current nibble |

## Verification
A wrong nibble counter or a wrong snapshot shows up at the first link rising edge that carries the bad nibble. That can be as soon as one link period after the fault, and at most one frame later. Where the fault appears, and whether start-of-frame moves or the data goes wrong, tells apart a counter fault from a packing fault or a latch fault. A fault in the divider shows within one half period as a wrong high or low time, or as data moving outside the falling edge. Changing the inputs in the middle of a frame shows that nothing reaches the link outside the frame start.

// File: rtl/nib_tx_pkg.sv
package nib_tx_pkg;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned FRAME_NIBS = 32;
  localparam int unsigned FRAME_W    = NIB_W * FRAME_NIBS;
  localparam int unsigned IDX_W      = $clog2(FRAME_NIBS);
  localparam int unsigned ROWS       = 8;
  localparam int unsigned JOY_W      = 5;
  localparam int unsigned JOY_FIRE   = 4;
endpackage

// File: rtl/nib_link_clk.sv
module nib_link_clk #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic link_clk_o,
  output logic fall_tick_o
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic          clk_q;
  logic          tick;

  assign tick        = (div_q == LAST);
  assign fall_tick_o = tick & clk_q;
  assign link_clk_o  = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      clk_q <= 1'b1;
    end else if (tick) begin
      div_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R2
  half_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_q) |-> $past(div_q) == LAST);
endmodule

// File: rtl/nib_frame_pack.sv
module nib_frame_pack
  import nib_tx_pkg::*;
#(
  parameter int unsigned NUM_COLS = 9
) (
  input  logic [NUM_COLS*ROWS-1:0] keys_i,
  input  logic [JOY_W-1:0]         joy1_i,
  input  logic [JOY_W-1:0]         joy2_i,
  input  logic                     caps_i,
  input  logic                     restore_i,
  input  logic                     reset_sw_i,
  output logic [FRAME_W-1:0]       frame_o
);
  localparam int unsigned J1_NIB = 2 * NUM_COLS;
  localparam int unsigned J1_AUX = J1_NIB + 1;
  localparam int unsigned J2_NIB = J1_NIB + 2;
  localparam int unsigned J2_AUX = J1_NIB + 3;

  logic [FRAME_W-1:0] keys_part;

  // two half-column nibbles per key column: low rows first
  for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
    assign keys_part[(2*k)*NIB_W   +: NIB_W] = keys_i[k*ROWS        +: NIB_W];
    assign keys_part[(2*k+1)*NIB_W +: NIB_W] = keys_i[k*ROWS+NIB_W  +: NIB_W];
  end
  assign keys_part[FRAME_W-1:NUM_COLS*ROWS] = '0;

  always_comb begin
    frame_o = keys_part;
    frame_o[J1_NIB*NIB_W +: NIB_W] = joy1_i[NIB_W-1:0];
    frame_o[J1_AUX*NIB_W +: NIB_W] = {restore_i, caps_i, 1'b0, joy1_i[JOY_FIRE]};
    frame_o[J2_NIB*NIB_W +: NIB_W] = joy2_i[NIB_W-1:0];
    frame_o[J2_AUX*NIB_W +: NIB_W] = {reset_sw_i, 2'b00, joy2_i[JOY_FIRE]};
  end
endmodule

// File: rtl/nib_frame_tx.sv
module nib_frame_tx
  import nib_tx_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned NUM_COLS = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_COLS*8-1:0]    keys_i,
  input  logic [4:0]               joy1_i,
  input  logic [4:0]               joy2_i,
  input  logic                     caps_i,
  input  logic                     restore_i,
  input  logic                     reset_sw_i,
  output logic                     link_clk_o,
  output logic                     link_sof_o,
  output logic [3:0]               link_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_NIBS - 1);
  localparam int unsigned      EXP_NIB  = 2 * NUM_COLS + 4;

  logic                 fall_tick;
  logic [FRAME_W-1:0]   frame_d, frame_q;
  logic [IDX_W-1:0]     idx_q;

  nib_link_clk #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .link_clk_o (link_clk_o),
    .fall_tick_o(fall_tick)
  );

  nib_frame_pack #(.NUM_COLS(NUM_COLS)) u_pack (
    .keys_i     (keys_i),
    .joy1_i     (joy1_i),
    .joy2_i     (joy2_i),
    .caps_i     (caps_i),
    .restore_i  (restore_i),
    .reset_sw_i (reset_sw_i),
    .frame_o    (frame_d)
  );

  // reset parks on the last nibble so the first fall opens a fresh frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= LAST_IDX;
      frame_q <= '0;
    end else if (fall_tick) begin
      if (idx_q == LAST_IDX) begin
        idx_q   <= '0;
        frame_q <= frame_d;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign link_data_o = frame_q[{idx_q, 2'b00} +: NIB_W];
  assign link_sof_o  = (idx_q == '0);

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_clk_o && $past(link_clk_o)) |-> ($stable(link_data_o) && $stable(link_sof_o)));
  // R4
  sof_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_sof_o) |-> $fell(link_clk_o));
  // R9
  snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_q) |-> link_sof_o);
  // R8
  exp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx_q) >= EXP_NIB) |-> (link_data_o == 4'h0));
endmodule

// File: tb/nib_frame_tx_test.sv
module nib_frame_tx_test;
  localparam int HALF = 3;
  localparam int COLS = 9;
  localparam int KW   = COLS * 8;
  localparam int VW   = KW + 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [KW-1:0] keys = '0;
  logic [4:0] joy1 = '0, joy2 = '0;
  logic caps = 1'b0, restore = 1'b0, reset_sw = 1'b0;
  logic lclk, sof;
  logic [3:0] data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nib_frame_tx #(.HALF_DIV(HALF), .NUM_COLS(COLS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .keys_i(keys), .joy1_i(joy1), .joy2_i(joy2),
    .caps_i(caps), .restore_i(restore), .reset_sw_i(reset_sw),
    .link_clk_o(lclk), .link_sof_o(sof), .link_data_o(data)
  );

  function automatic logic [3:0] exp_nib(int n, logic [VW-1:0] v);
    logic [KW-1:0] k;
    logic [4:0] j1, j2;
    k  = v[KW-1:0];
    j1 = v[KW+4:KW];
    j2 = v[KW+9:KW+5];
    if (n < 2*COLS) return k[4*n +: 4];
    if (n == 2*COLS)     return j1[3:0];
    if (n == 2*COLS + 1) return {v[KW+11], v[KW+10], 1'b0, j1[4]};
    if (n == 2*COLS + 2) return j2[3:0];
    if (n == 2*COLS + 3) return {v[KW+12], 2'b00, j2[4]};
    return 4'h0;
  endfunction

  function automatic string tag_of(int n);
    if (n < 2*COLS) return "R5";
    if (n == 2*COLS || n == 2*COLS + 2) return "R6";
    if (n < 2*COLS + 4) return "R7";
    return "R8";
  endfunction

  function automatic logic [VW-1:0] cur_vec();
    return {reset_sw, restore, caps, joy2, joy1, keys};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: independent model of link timing and frame content
  logic [VW-1:0] snap = '0;
  int  rx_idx = 0;
  int  since = 0;
  int  toggles = 0;
  logic prev_lclk = 1'b1, prev_sof = 1'b0;
  logic [3:0] prev_data = 4'h0;
  int  rises = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since++;
      if (lclk !== prev_lclk) begin
        toggles++;
        if (toggles > 1) check(since == HALF, "R2", since, HALF);
        since = 0;
      end
      if ((data !== prev_data || sof !== prev_sof) && !(prev_lclk && !lclk))
        check(1'b0, "R3", {sof, data}, {prev_sof, prev_data});
      if (prev_lclk && !lclk && rx_idx == 0) snap = cur_vec();
      if (!prev_lclk && lclk) begin
        check(sof == (rx_idx == 0), "R4", sof, rx_idx == 0);
        check(data == exp_nib(rx_idx, snap), {tag_of(rx_idx), " R9"},
              data, exp_nib(rx_idx, snap));
        rx_idx = (rx_idx + 1) % 32;
        rises++;
      end
      prev_lclk = lclk;
      prev_sof  = sof;
      prev_data = data;
    end
  end

  task automatic wait_rises(int n);
    int target;
    target = rises + n;
    while (rises < target) @(negedge clk);
  endtask

  task automatic apply(logic [VW-1:0] v, int hold);
    wait_rises(1);
    {reset_sw, restore, caps, joy2, joy1, keys} = v;
    wait_rises(hold);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    // R1
    check(lclk == 1'b1, "R1", lclk, 1);
    check(sof == 1'b0, "R1", sof, 0);
    check(data == 4'h0, "R1", data, 0);
    rst_n = 1'b1;
    apply('0, 40);
    apply('1, 40);
    for (int b = 0; b < VW; b++) apply(VW'(1) << b, 34);
    for (int p = 0; p < 12; p++) begin
      logic [VW-1:0] v;
      for (int i = 0; i < VW; i++) v[i] = ((i * 7 + p * 13) % 5) < 2;
      apply(v, (p % 2) ? 5 : 34);
    end
    // R9: rapid mid-frame changes
    for (int p = 0; p < 16; p++) apply({VW{p[0]}} ^ (VW'(p) << (p * 5)), 3);
    apply('0, 70);
    check(rises > 3000, "R4", rises, 3000);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #700000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog act=%0d exp=%0d", rises, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule